// File: doc/BRIEF.md
# Three-by-Three Multi-Picture Decimator

This block builds a mosaic of nine reduced pictures in a field memory without a separate picture-in-picture engine. Source video enters one pixel per strobe, framed by a field marker and a line marker. The block keeps one pixel out of every three along each line and one line out of every three down each field. It turns each kept pixel into a write strobe, a memory address and a data word.

The memory holds a grid of three tiles across and three tiles down. A 4-bit selector names the tile that receives the current field. Only that tile is rewritten, so the other eight keep their last contents as still pictures. The selector is sampled only on the field marker, so a field is never split between two tiles. The display side reads the memory on its own timing and has no link to the source timing.

Top module: `mpip_decimator`

## Requirements
- R1: After reset, and until a field marker has sampled a selector value from 0 to 8, `wr_en` stays low whatever the other inputs do.
- R2: Within a line, accepted pixels are numbered from 0 starting after `line_start`. Pixel i is kept only when i mod 3 is 0, and it goes to column i/3. Pixels whose column would be TILE_W or more are dropped.
- R3: Within a field, lines are numbered from 0 at the first `line_start` after `field_start`. Line j is kept only when j mod 3 is 0, and it goes to row j/3. Lines whose row would be TILE_H or more are dropped.
- R4: The memory is row-major with a pitch of 3*TILE_W words per row. A kept pixel of tile t at row r and column c is written to address (t/3)*TILE_H*3*TILE_W + (t mod 3)*TILE_W + r*3*TILE_W + c. Tiles are numbered 0 to 8, row by row from the top left.
- R5: If `live_sel` is 9 to 15 when the field marker samples it, no write happens during that field.
- R6: A change of `live_sel` inside a field does not affect that field. The new value is used from the next `field_start`.
- R7: `wr_en`, `wr_addr` and `wr_data` are registered. They appear one clock after the kept pixel is sampled, and `wr_data` equals the `pix_data` of that pixel.
- R8: A pixel strobe is ignored if it arrives in the same cycle as `line_start` or `field_start`, or after `field_start` but before the first `line_start` of that field.
- R9: Every write address lies inside the rectangle of the tile selected for the current field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| field_start | input | 1 | One-cycle marker at the start of a source field |
| line_start | input | 1 | One-cycle marker at the start of an active source line |
| pix_valid | input | 1 | Source pixel strobe |
| pix_data | input | DW | Source pixel value |
| live_sel | input | 4 | Live tile selector; 0 to 8 picks a tile, 9 to 15 disables writes |
| wr_en | output | 1 | Field memory write strobe |
| wr_addr | output | AW | Field memory word address |
| wr_data | output | DW | Field memory write data |

## Verification
The bench sends lines that are wider and fields that are taller than one tile can hold. A design that does not saturate its column or row index would then write into the next tile. The bench changes the selector in the middle of a field and also gives an out-of-range selector; a design that samples the selector on every cycle would split a field between two tiles or write while disabled. It sends pixel strobes together with a line marker, and before the first line of a field. A decimation phase that starts on the wrong pixel or line shows up as wrong addresses or data. A pass over all nine tiles checks each tile origin, where a swapped row and column term in the address would move the pictures to the wrong places.

// File: rtl/mpip_pkg.sv
package mpip_pkg;

  localparam int unsigned GRID      = 3;
  localparam int unsigned NUM_TILES = GRID * GRID;

  typedef logic [3:0] tile_idx_t;

  // Word offset of the top-left corner of tile t in a row-major memory
  // whose pitch is GRID tiles wide.
  function automatic int unsigned tile_origin(input int unsigned t,
                                              input int unsigned tw,
                                              input int unsigned th);
    int unsigned pitch;
    pitch = GRID * tw;
    return (t / GRID) * th * pitch + (t % GRID) * tw;
  endfunction

endpackage

// File: rtl/mpip_phase_ctr.sv
// Modulo-3 decimation phase with a saturating output index.
module mpip_phase_ctr #(
  parameter int unsigned LIMIT = 16,
  localparam int unsigned IW   = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic          keep,
  output logic [IW-1:0] idx
);

  logic [1:0]    phase_q, phase_d;
  logic [IW-1:0] idx_q, idx_d;

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    if (clr) begin
      phase_d = 2'd0;
      idx_d   = '0;
    end else if (step) begin
      if (phase_q == 2'd2) begin
        phase_d = 2'd0;
        if (idx_q != IW'(LIMIT)) begin
          idx_d = idx_q + 1'b1;
        end
      end else begin
        phase_d = phase_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 2'd0;
      idx_q   <= '0;
    end else if (clr || step) begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
    end
  end

  assign keep = (phase_q == 2'd0) && (idx_q < IW'(LIMIT));
  assign idx  = idx_q;

endmodule

// File: rtl/mpip_tile_sel.sv
// Latches the live tile at field start and provides its memory origin.
module mpip_tile_sel
  import mpip_pkg::*;
#(
  parameter int unsigned TILE_W = 16,
  parameter int unsigned TILE_H = 12,
  parameter int unsigned AW     = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          field_start,
  input  tile_idx_t     live_sel,
  output logic          tile_ok,
  output logic [AW-1:0] origin
);

  logic [AW-1:0] org_tab [NUM_TILES];

  for (genvar g = 0; g < NUM_TILES; g++) begin : g_org
    assign org_tab[g] = AW'(tile_origin(g, TILE_W, TILE_H));
  end

  tile_idx_t     tile_q, tile_d;
  logic [AW-1:0] origin_q, origin_d;

  always_comb begin
    tile_d   = tile_q;
    origin_d = origin_q;
    if (field_start) begin
      tile_d   = live_sel;
      origin_d = '0;
      for (int k = 0; k < NUM_TILES; k++) begin
        if (live_sel == tile_idx_t'(k)) begin
          origin_d = org_tab[k];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tile_q   <= 4'hF;
      origin_q <= '0;
    end else if (field_start) begin
      tile_q   <= tile_d;
      origin_q <= origin_d;
    end
  end

  assign tile_ok = (tile_q < tile_idx_t'(NUM_TILES));
  assign origin  = origin_q;

endmodule

// File: rtl/mpip_wr_gen.sv
// Builds the registered write strobe, address and data.
module mpip_wr_gen #(
  parameter int unsigned PITCH = 48,
  parameter int unsigned AW    = 10,
  parameter int unsigned CW    = 5,
  parameter int unsigned RW    = 4,
  parameter int unsigned DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          keep_h,
  input  logic          keep_v,
  input  logic          tile_ok,
  input  logic [AW-1:0] origin,
  input  logic [RW-1:0] row,
  input  logic [CW-1:0] col,
  input  logic [DW-1:0] pix_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);

  logic          en_q, en_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;
  logic          hit;

  always_comb begin
    hit    = accept && keep_h && keep_v && tile_ok;
    en_d   = hit;
    addr_d = addr_q;
    data_d = data_q;
    if (hit) begin
      addr_d = origin + AW'(row) * AW'(PITCH) + AW'(col);
      data_d = pix_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (hit) begin
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign wr_en   = en_q;
  assign wr_addr = addr_q;
  assign wr_data = data_q;

endmodule

// File: rtl/mpip_decimator.sv
module mpip_decimator
  import mpip_pkg::*;
#(
  parameter int unsigned TILE_W = 16,
  parameter int unsigned TILE_H = 12,
  parameter int unsigned DW     = 8,
  localparam int unsigned PITCH = GRID * TILE_W,
  localparam int unsigned WORDS = PITCH * GRID * TILE_H,
  localparam int unsigned AW    = $clog2(WORDS),
  localparam int unsigned CW    = $clog2(TILE_W + 1),
  localparam int unsigned RW    = $clog2(TILE_H + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          field_start,
  input  logic          line_start,
  input  logic          pix_valid,
  input  logic [DW-1:0] pix_data,
  input  logic [3:0]    live_sel,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);

  logic          line_open_q, line_open_d;
  logic          marker;
  logic          accept;
  logic          h_clr, h_step, v_clr, v_step;
  logic          keep_h, keep_v;
  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic          tile_ok;
  logic [AW-1:0] origin;

  // Line framing: a line is open from its marker until the next field marker.
  always_comb begin
    line_open_d = line_open_q;
    if (field_start) begin
      line_open_d = 1'b0;
    end else if (line_start) begin
      line_open_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_open_q <= 1'b0;
    end else if (field_start || line_start) begin
      line_open_q <= line_open_d;
    end
  end

  assign marker = field_start || line_start;
  assign accept = pix_valid && line_open_q && !marker;
  assign h_clr  = marker;
  assign h_step = accept;
  assign v_clr  = field_start;
  assign v_step = line_start && line_open_q && !field_start;

  mpip_phase_ctr #(.LIMIT(TILE_W)) u_hctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (h_clr),
    .step  (h_step),
    .keep  (keep_h),
    .idx   (col)
  );

  mpip_phase_ctr #(.LIMIT(TILE_H)) u_vctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (v_clr),
    .step  (v_step),
    .keep  (keep_v),
    .idx   (row)
  );

  mpip_tile_sel #(
    .TILE_W (TILE_W),
    .TILE_H (TILE_H),
    .AW     (AW)
  ) u_tsel (
    .clk         (clk),
    .rst_n       (rst_n),
    .field_start (field_start),
    .live_sel    (live_sel),
    .tile_ok     (tile_ok),
    .origin      (origin)
  );

  mpip_wr_gen #(
    .PITCH (PITCH),
    .AW    (AW),
    .CW    (CW),
    .RW    (RW),
    .DW    (DW)
  ) u_wgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .keep_h   (keep_h),
    .keep_v   (keep_v),
    .tile_ok  (tile_ok),
    .origin   (origin),
    .row      (row),
    .col      (col),
    .pix_data (pix_data),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

endmodule

// File: rtl/mpip_decimator_chk.sv
module mpip_decimator_chk #(
  parameter int unsigned TILE_W = 16,
  parameter int unsigned TILE_H = 12,
  parameter int unsigned DW     = 8,
  parameter int unsigned AW     = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          field_start,
  input logic          line_start,
  input logic          pix_valid,
  input logic [DW-1:0] pix_data,
  input logic [3:0]    live_sel,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data
);

  localparam int unsigned PITCH = 3 * TILE_W;
  localparam int unsigned WORDS = PITCH * 3 * TILE_H;

  logic [3:0] field_tile;
  logic       in_tile;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_tile <= 4'hF;
    end else if (field_start) begin
      field_tile <= live_sel;
    end
  end

  always_comb begin
    int unsigned a, r, c, tr, tc;
    a  = int'(wr_addr);
    r  = a / PITCH;
    c  = a % PITCH;
    tr = int'(field_tile) / 3;
    tc = int'(field_tile) % 3;
    in_tile = (field_tile < 4'd9) &&
              (c >= tc * TILE_W) && (c < (tc + 1) * TILE_W) &&
              (r >= tr * TILE_H) && (r < (tr + 1) * TILE_H);
  end

  AST_WR_FROM_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(pix_valid)); // R2

  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < WORDS)); // R4

  AST_DATA_FOLLOWS_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data == $past(pix_data))); // R7

  AST_MARKER_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start || field_start) |=> !wr_en); // R8

  AST_DISABLED_FIELD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (field_tile > 4'd8) |-> !wr_en); // R5

  AST_ADDR_IN_TILE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> in_tile); // R9

endmodule

bind mpip_decimator mpip_decimator_chk #(
  .TILE_W (TILE_W),
  .TILE_H (TILE_H),
  .DW     (DW),
  .AW     (AW)
) u_chk (.*);

// File: tb/mpip_decimator_tb.sv
module mpip_decimator_tb;

  localparam int TW    = 4;
  localparam int TH    = 3;
  localparam int DW    = 8;
  localparam int PITCH = 3 * TW;
  localparam int AW    = $clog2(PITCH * 3 * TH);

  typedef struct {
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } exp_t;

  logic          clk;
  logic          rst_n;
  logic          field_start;
  logic          line_start;
  logic          pix_valid;
  logic [DW-1:0] pix_data;
  logic [3:0]    live_sel;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  exp_t  sb_q[$];
  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R1";
  int    tb_tile = 15;

  mpip_decimator #(.TILE_W(TW), .TILE_H(TH), .DW(DW)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .field_start (field_start),
    .line_start  (line_start),
    .pix_valid   (pix_valid),
    .pix_data    (pix_data),
    .live_sel    (live_sel),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic summary_and_end();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    summary_and_end();
  end

  // Monitor: pop and compare at the falling edge.
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (sb_q.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL %s unexpected write actual=addr %0d expected=no write", cur_req, wr_addr);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (wr_addr !== e.addr) begin
          fails++;
          $display("FAIL R4 address (R2 R3 placement) actual=%0d expected=%0d", wr_addr, e.addr);
        end
        checks++;
        if (wr_data !== e.data) begin
          fails++;
          $display("FAIL R7 data actual=%0h expected=%0h", wr_data, e.data);
        end
      end
    end
  end

  task automatic drive(input logic fs, input logic ls, input logic pv, input logic [DW-1:0] pd);
    field_start = fs;
    line_start  = ls;
    pix_valid   = pv;
    pix_data    = pd;
    @(posedge clk);
    #2;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic check_drained(input string req);
    idle(3);
    checks++;
    if (sb_q.size() != 0) begin
      fails++;
      $display("FAIL %s missing writes actual=%0d pending expected=0", req, sb_q.size());
      sb_q.delete();
    end
  endtask

  function automatic logic [DW-1:0] pix_val(int fid, int j, int i);
    return DW'((fid * 53 + j * 16 + i) & 255);
  endfunction

  // Drives one field and pushes the writes the requirements predict.
  task automatic run_field(input int sel, input int nlines, input int npix,
                           input int chg_line, input int chg_sel, input int fid);
    exp_t e;
    live_sel = 4'(sel);
    drive(1'b1, 1'b0, 1'b0, '0);
    tb_tile = sel;
    // R8: pixel before the first line of the field is ignored.
    drive(1'b0, 1'b0, 1'b1, 8'hEE);
    for (int j = 0; j < nlines; j++) begin
      if (j == chg_line) live_sel = 4'(chg_sel);
      // R8: pixel coincident with the line marker is ignored.
      drive(1'b0, 1'b1, 1'b1, 8'hDD);
      for (int i = 0; i < npix; i++) begin
        if (tb_tile < 9 && (j % 3) == 0 && (j / 3) < TH && (i % 3) == 0 && (i / 3) < TW) begin
          e.addr = AW'((tb_tile / 3) * TH * PITCH + (tb_tile % 3) * TW + (j / 3) * PITCH + (i / 3));
          e.data = pix_val(fid, j, i);
          sb_q.push_back(e);
        end
        drive(1'b0, 1'b0, 1'b1, pix_val(fid, j, i));
        if ((i % 5) == 4) idle(1);
      end
      idle(2);
    end
  endtask

  initial begin
    rst_n       = 1'b0;
    field_start = 1'b0;
    line_start  = 1'b0;
    pix_valid   = 1'b0;
    pix_data    = '0;
    live_sel    = 4'd0;
    repeat (4) @(negedge clk);
    checks++;
    if (wr_en !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset wr_en actual=%b expected=0", wr_en);
    end
    @(posedge clk);
    #2;
    rst_n = 1'b1;
    idle(2);

    // R1: line and pixels with no field marker since reset.
    cur_req = "R1";
    drive(1'b0, 1'b1, 1'b0, '0);
    for (int i = 0; i < 9; i++) drive(1'b0, 1'b0, 1'b1, DW'(i));
    check_drained("R1");

    // R2 R3 R4 R7 R8: basic field into tile 0.
    cur_req = "R2 R3 R8";
    run_field(0, 7, 10, -1, 0, 1);
    check_drained("R2 R3 R7");

    // R2 R3: oversize lines and field into the centre tile (saturation).
    cur_req = "R2 R3 saturation";
    run_field(4, 12, 16, -1, 0, 2);
    check_drained("R2 R3 saturation");

    // R4: last tile.
    cur_req = "R4";
    run_field(8, 9, 12, -1, 0, 3);
    check_drained("R4");

    // R5: out-of-range selector disables the field.
    cur_req = "R5";
    run_field(11, 9, 12, -1, 0, 4);
    check_drained("R5");

    // R6: selector change mid-field takes effect at next field.
    cur_req = "R6";
    run_field(2, 7, 12, 2, 5, 5);
    check_drained("R6 same field");
    run_field(5, 4, 9, -1, 0, 6);
    check_drained("R6 next field");

    // R4 R9: every tile origin.
    for (int t = 0; t < 9; t++) begin
      cur_req = "R4 R9";
      run_field(t, 4, 7, -1, 0, 10 + t);
      check_drained("R4 R9");
    end

    summary_and_end();
  end

endmodule